// File: doc/BRIEF.md
# LAN Controller Status and Interrupt Block

This block is the host-facing control slice of a token-passing network controller. It holds an 8-bit status word, a 3-bit interrupt mask and a command decoder. It raises one level interrupt, which a board-level enable gates. Event inputs come from the protocol engine: packet stored, transmit finished, acknowledge seen and broadcast. The block turns these into the status flags, and its outputs tell the engine which buffer page to receive into, which page to transmit from, and when receiving or transmitting is allowed.

A receive-line idle timer also lives here. It counts system clocks since the last edge on the synchronized receive line. When the line has been quiet for the reconfiguration interval, the timer sets the reconfiguration flag once. The interval is derived from the `CLK_HZ` and `IDLE_NS` parameters. The receive line and the two extended-timeout pins each pass through a two-flop synchronizer. Commands are one byte wide: the opcode sits in bits [2:0] and the page number in bits [7:3].

Top module: `lanc_status_ctrl`

## Requirements
- R1: Status bit layout: [0] receive inhibit, [1] reconfiguration, [2] transmit available, [3] transmit acknowledge, [4] power-on reset, [5] test, [6] and [7] extended-timeout pins 0 and 1. After reset, bits 0, 2 and 4 are 1 and bits 1, 3 and 5 are 0. The mask, rx_en_o, tx_req_o and both page outputs are 0.
- R2: If pkt_done_i is seen while receive inhibit is 0, receive inhibit is 1 from the next cycle and rx_en_o is 0. If pkt_done_i is seen while receive inhibit is 1, it has no effect.
- R3: Opcode 4 (enable receive) clears receive inhibit, drives rx_en_o high and latches cmd_i[7:3] onto rx_page_o. If pkt_done_i arrives in the same cycle, the command wins.
- R4: The reconfiguration flag is set after IDLE_CYC = CLK_HZ*IDLE_NS/1e9 consecutive clocks with no edge on the synchronized receive line. It is set once per idle period. Opcode 1 clears it, but a timeout in the same cycle wins.
- R5: Opcode 1 (clear flags) clears power-on reset and reconfiguration and leaves every other flag unchanged.
- R6: Opcode 3 (start transmit) issued while transmit available is 1 clears transmit available and transmit acknowledge, raises tx_req_o and latches cmd_i[7:3] onto tx_page_o. The same opcode is ignored while transmit available is 0.
- R7: If tx_done_i arrives while tx_req_o is high, tx_req_o drops, transmit available is set, and transmit acknowledge becomes tx_ack_i AND NOT tx_bcast_i. If tx_done_i arrives without a pending request, it is ignored.
- R8: Opcode 2 (disable transmitter) sets transmit available and drops tx_req_o on the next cycle. It takes priority over tx_done_i in the same cycle.
- R9: The test bit reads 0. Status bits 6 and 7 follow xto_pin_i[0] and xto_pin_i[1] two clocks later.
- R10: irq_o = board_ie_i AND (power-on reset OR (receive inhibit AND mask[0]) OR (reconfiguration AND mask[1]) OR (transmit available AND mask[2])). It is combinational from the flags, the mask and board_ie_i.
- R11: Opcodes 0, 5, 6 and 7 change no state, whatever the page field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | CMD_W | Command byte: opcode [2:0], page [CMD_W-1:3] |
| mask_we_i | input | 1 | Interrupt mask write strobe |
| mask_i | input | 3 | Mask bits for receive inhibit, reconfiguration, transmit available |
| board_ie_i | input | 1 | Board-level interrupt enable |
| xto_pin_i | input | 2 | Extended-timeout configuration pins |
| rx_line_i | input | 1 | Raw receive line, watched for activity |
| pkt_done_i | input | 1 | Engine stored a received packet |
| tx_done_i | input | 1 | Engine finished a transmission |
| tx_ack_i | input | 1 | Transmission was acknowledged (valid with tx_done_i) |
| tx_bcast_i | input | 1 | Transmission was a broadcast (valid with tx_done_i) |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Level interrupt |
| rx_en_o | output | 1 | Reception armed |
| rx_page_o | output | CMD_W-3 | Receive buffer page |
| tx_req_o | output | 1 | Transmit request to engine |
| tx_page_o | output | CMD_W-3 | Transmit buffer page |

## Verification
The command decoder is driven with every opcode, with page fields that differ from the latched pages. This separates opcodes that really act from opcodes that merely appear to act. It also shows that a start-transmit issued during a pending transmission leaves the latched page alone.

Transmit completions are tried in three forms: acknowledged unicast, acknowledged broadcast, and a completion with no request pending. Together these separate the acknowledge qualification from the handling of stray events.

The receive line is tried in two patterns. First it toggles every cycle, then it is held quiet for more than one interval. This shows that the timer is reloaded by activity and fires once per idle period. A packet arriving together with a receive command exposes the priority between them. Every flag and output is compared against the reference model on each clock.

// File: rtl/lanc_pkg.sv
`timescale 1ns/1ps
package lanc_pkg;
  localparam int ST_RXI  = 0;
  localparam int ST_RCF  = 1;
  localparam int ST_TXA  = 2;
  localparam int ST_TACK = 3;
  localparam int ST_POR  = 4;
  localparam int ST_TST  = 5;
  localparam int ST_XT0  = 6;
  localparam int ST_XT1  = 7;
  localparam int ST_W    = 8;
  localparam int OP_W    = 3;
  localparam int MASK_W  = 3;

  localparam logic [OP_W-1:0] OP_CLR   = 3'd1;
  localparam logic [OP_W-1:0] OP_TXOFF = 3'd2;
  localparam logic [OP_W-1:0] OP_TXGO  = 3'd3;
  localparam logic [OP_W-1:0] OP_RXGO  = 3'd4;

  typedef struct packed {
    logic clr;
    logic tx_off;
    logic tx_go;
    logic rx_go;
  } cmd_evt_t;
endpackage

// File: rtl/lanc_sync.sv
`timescale 1ns/1ps
module lanc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= d_i;
      else             pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/lanc_idle_timer.sv
`timescale 1ns/1ps
module lanc_idle_timer #(
  parameter int unsigned IDLE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic expire_o
);
  localparam int unsigned LAST  = IDLE_CYC - 1;
  localparam int          CNT_W = (IDLE_CYC > 2) ? $clog2(IDLE_CYC) : 1;

  logic             line_q, armed_q, edge_s;
  logic [CNT_W-1:0] cnt_q;

  assign edge_s   = line_i ^ line_q;
  assign expire_o = armed_q && !edge_s && (cnt_q == CNT_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= 1'b0;
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      line_q <= line_i;
      if (edge_s) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (expire_o) begin
        armed_q <= 1'b0;  // hold until next edge: one flag per idle period
      end else if (armed_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lanc_cmd_dec.sv
`timescale 1ns/1ps
module lanc_cmd_dec import lanc_pkg::*; #(
  parameter int CMD_W = 8
) (
  input  logic                  we_i,
  input  logic [CMD_W-1:0]      cmd_i,
  output cmd_evt_t              evt_o,
  output logic [CMD_W-OP_W-1:0] page_o
);
  assign page_o = cmd_i[CMD_W-1:OP_W];

  always_comb begin
    evt_o = '0;
    if (we_i) begin
      case (cmd_i[OP_W-1:0])
        OP_CLR:   evt_o.clr    = 1'b1;
        OP_TXOFF: evt_o.tx_off = 1'b1;
        OP_TXGO:  evt_o.tx_go  = 1'b1;
        OP_RXGO:  evt_o.rx_go  = 1'b1;
        default:  evt_o        = '0;
      endcase
    end
  end
endmodule

// File: rtl/lanc_status_ctrl.sv
`timescale 1ns/1ps
module lanc_status_ctrl import lanc_pkg::*; #(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned IDLE_NS     = 78_200,
  parameter int          CMD_W       = 8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_we_i,
  input  logic [CMD_W-1:0]        cmd_i,
  input  logic                    mask_we_i,
  input  logic [MASK_W-1:0]       mask_i,
  input  logic                    board_ie_i,
  input  logic [1:0]              xto_pin_i,
  input  logic                    rx_line_i,
  input  logic                    pkt_done_i,
  input  logic                    tx_done_i,
  input  logic                    tx_ack_i,
  input  logic                    tx_bcast_i,
  output logic [ST_W-1:0]         status_o,
  output logic                    irq_o,
  output logic                    rx_en_o,
  output logic [CMD_W-OP_W-1:0]   rx_page_o,
  output logic                    tx_req_o,
  output logic [CMD_W-OP_W-1:0]   tx_page_o
);
  localparam int PAGE_W = CMD_W - OP_W;
  localparam longint unsigned IDLE_L =
    (64'(CLK_HZ) * 64'(IDLE_NS)) / 64'd1_000_000_000;
  localparam int unsigned IDLE_CYC = (IDLE_L < 2) ? 2 : 32'(IDLE_L);

  logic [2:0]        sync_q;
  logic              expire;
  cmd_evt_t          evt;
  logic [PAGE_W-1:0] page;

  logic rxi_q, rcf_q, por_q, txa_q, tack_q, txreq_q;
  logic [PAGE_W-1:0] rx_page_q, tx_page_q;
  logic [MASK_W-1:0] mask_q;

  lanc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({xto_pin_i, rx_line_i}),
    .q_o   (sync_q)
  );

  lanc_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (sync_q[0]),
    .expire_o(expire)
  );

  lanc_cmd_dec #(.CMD_W(CMD_W)) u_dec (
    .we_i  (cmd_we_i),
    .cmd_i (cmd_i),
    .evt_o (evt),
    .page_o(page)
  );

  // receive side: command re-arm beats a same-cycle packet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxi_q     <= 1'b1;
      rx_page_q <= '0;
    end else if (evt.rx_go) begin
      rxi_q     <= 1'b0;
      rx_page_q <= page;
    end else if (pkt_done_i && !rxi_q) begin
      rxi_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q <= 1'b1;
      rcf_q <= 1'b0;
    end else begin
      if (evt.clr) por_q <= 1'b0;
      if (expire)       rcf_q <= 1'b1;
      else if (evt.clr) rcf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txa_q     <= 1'b1;
      tack_q    <= 1'b0;
      txreq_q   <= 1'b0;
      tx_page_q <= '0;
    end else if (evt.tx_off) begin
      txa_q   <= 1'b1;
      txreq_q <= 1'b0;
    end else if (evt.tx_go && txa_q) begin
      txa_q     <= 1'b0;
      tack_q    <= 1'b0;
      txreq_q   <= 1'b1;
      tx_page_q <= page;
    end else if (tx_done_i && txreq_q) begin
      txa_q   <= 1'b1;
      txreq_q <= 1'b0;
      tack_q  <= tx_ack_i && !tx_bcast_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_i;
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_RXI]  = rxi_q;
    status_o[ST_RCF]  = rcf_q;
    status_o[ST_TXA]  = txa_q;
    status_o[ST_TACK] = tack_q;
    status_o[ST_POR]  = por_q;
    status_o[ST_TST]  = 1'b0;
    status_o[ST_XT0]  = sync_q[1];
    status_o[ST_XT1]  = sync_q[2];
  end

  assign irq_o     = board_ie_i &&
                     (por_q || (rxi_q && mask_q[0]) ||
                      (rcf_q && mask_q[1]) || (txa_q && mask_q[2]));
  assign rx_en_o   = !rxi_q;
  assign rx_page_o = rx_page_q;
  assign tx_req_o  = txreq_q;
  assign tx_page_o = tx_page_q;
endmodule

// File: rtl/lanc_status_chk.sv
`timescale 1ns/1ps
module lanc_status_chk import lanc_pkg::*; #(
  parameter int CMD_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cmd_we_i,
  input logic [CMD_W-1:0]      cmd_i,
  input logic                  board_ie_i,
  input logic                  pkt_done_i,
  input logic                  tx_done_i,
  input logic                  tx_bcast_i,
  input logic [ST_W-1:0]       status_o,
  input logic                  irq_o,
  input logic                  rx_en_o,
  input logic [CMD_W-OP_W-1:0] rx_page_o,
  input logic                  tx_req_o,
  input logic [CMD_W-OP_W-1:0] tx_page_o
);
  logic op_clr, op_txoff, op_txgo, op_rxgo;
  assign op_clr   = cmd_we_i && cmd_i[OP_W-1:0] == OP_CLR;
  assign op_txoff = cmd_we_i && cmd_i[OP_W-1:0] == OP_TXOFF;
  assign op_txgo  = cmd_we_i && cmd_i[OP_W-1:0] == OP_TXGO;
  assign op_rxgo  = cmd_we_i && cmd_i[OP_W-1:0] == OP_RXGO;

  // R2
  pkt_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i && rx_en_o && !op_rxgo) |=> (!rx_en_o && status_o[ST_RXI]));
  // R3
  rx_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_rxgo |=> (rx_en_o && rx_page_o == $past(cmd_i[CMD_W-1:OP_W])));
  // R5
  por_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_clr |=> !status_o[ST_POR]);
  // R6
  tx_busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && op_txgo && !tx_done_i) |=> (tx_req_o && $stable(tx_page_o)));
  // R7
  bcast_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && tx_done_i && tx_bcast_i && !op_txoff)
      |=> (!status_o[ST_TACK] && status_o[ST_TXA]));
  // R8
  tx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_txoff |=> (status_o[ST_TXA] && !tx_req_o));
  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !board_ie_i |-> !irq_o);
  // R10
  por_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (board_ie_i && status_o[ST_POR]) |-> irq_o);
endmodule

bind lanc_status_ctrl lanc_status_chk #(.CMD_W(CMD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_we_i  (cmd_we_i),
  .cmd_i     (cmd_i),
  .board_ie_i(board_ie_i),
  .pkt_done_i(pkt_done_i),
  .tx_done_i (tx_done_i),
  .tx_bcast_i(tx_bcast_i),
  .status_o  (status_o),
  .irq_o     (irq_o),
  .rx_en_o   (rx_en_o),
  .rx_page_o (rx_page_o),
  .tx_req_o  (tx_req_o),
  .tx_page_o (tx_page_o)
);

// File: tb/sim_lanc_status_ctrl.sv
`timescale 1ns/1ps
module sim_lanc_status_ctrl;
  localparam int unsigned CLK_HZ   = 200_000_000;
  localparam int unsigned IDLE_NS  = 400;
  localparam int          IDLE_CYC = 80;
  localparam int          CMD_W    = 8;
  localparam int          PW       = CMD_W - 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_we = 0, mask_we = 0, board_ie = 0, rx = 0;
  logic pkt = 0, txd = 0, ack = 0, bc = 0;
  logic [CMD_W-1:0] cmd = '0;
  logic [2:0] mask = '0;
  logic [1:0] xto = '0;
  logic [7:0] status;
  logic irq, rx_en, tx_req;
  logic [PW-1:0] rx_page, tx_page;

  lanc_status_ctrl #(.CLK_HZ(CLK_HZ), .IDLE_NS(IDLE_NS), .CMD_W(CMD_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .mask_we_i(mask_we), .mask_i(mask), .board_ie_i(board_ie),
    .xto_pin_i(xto), .rx_line_i(rx), .pkt_done_i(pkt), .tx_done_i(txd),
    .tx_ack_i(ack), .tx_bcast_i(bc), .status_o(status), .irq_o(irq),
    .rx_en_o(rx_en), .rx_page_o(rx_page), .tx_req_o(tx_req), .tx_page_o(tx_page)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  bit m_rxi, m_rcf, m_txa, m_tack, m_por, m_txreq;
  int m_rxpg, m_txpg, m_mask, idle_run;
  bit [2:0] hist[$];
  bit m_edge, m_exp;
  int m_op, m_pg;

  task automatic model_reset();
    m_rxi = 1; m_rcf = 0; m_txa = 1; m_tack = 0; m_por = 1; m_txreq = 0;
    m_rxpg = 0; m_txpg = 0; m_mask = 0; idle_run = 0;
    hist = '{3'b0, 3'b0, 3'b0};
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      m_edge = hist[1][0] != hist[0][0];
      hist.push_back({xto, rx});
      void'(hist.pop_front());
      if (m_edge) idle_run = 0; else idle_run++;
      m_exp = !m_edge && idle_run == IDLE_CYC;
      m_op = cmd_we ? int'(cmd[2:0]) : -1;
      m_pg = int'(cmd[CMD_W-1:3]);
      if (m_op == 4) begin m_rxi = 0; m_rxpg = m_pg; end
      else if (pkt && !m_rxi) m_rxi = 1;
      if (m_op == 1) m_por = 0;
      if (m_exp) m_rcf = 1; else if (m_op == 1) m_rcf = 0;
      if (m_op == 2) begin m_txa = 1; m_txreq = 0; end
      else if (m_op == 3 && m_txa) begin
        m_txa = 0; m_tack = 0; m_txreq = 1; m_txpg = m_pg;
      end else if (txd && m_txreq) begin
        m_txa = 1; m_txreq = 0; m_tack = ack && !bc;
      end
      if (mask_we) m_mask = int'(mask);
    end
  end

  task automatic compare_all();
    bit exp_irq;
    exp_irq = board_ie && (m_por || (m_rxi && m_mask[0]) ||
              (m_rcf && m_mask[1]) || (m_txa && m_mask[2]));
    chk("R2", "rx_inhibit", int'(status[0]), int'(m_rxi));
    chk("R4", "reconfig", int'(status[1]), int'(m_rcf));
    chk("R6", "tx_avail", int'(status[2]), int'(m_txa));
    chk("R7", "tx_ack", int'(status[3]), int'(m_tack));
    chk("R5", "por", int'(status[4]), int'(m_por));
    chk("R9", "test", int'(status[5]), 0);
    chk("R9", "xto", int'(status[7:6]), int'(hist[1][2:1]));
    chk("R10", "irq", int'(irq), int'(exp_irq));
    chk("R3", "rx_en", int'(rx_en), int'(!m_rxi));
    chk("R3", "rx_page", int'(rx_page), m_rxpg);
    chk("R6", "tx_req", int'(tx_req), int'(m_txreq));
    chk("R6", "tx_page", int'(tx_page), m_txpg);
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_cmd(int op, int pg);
    cmd_we = 1; cmd = CMD_W'((pg << 3) | op);
    tick();
    cmd_we = 0;
  endtask

  task automatic do_mask(logic [2:0] m);
    mask_we = 1; mask = m;
    tick();
    mask_we = 0;
  endtask

  bit rx_busy = 0;
  always @(negedge clk) if (rx_busy) rx <= ~rx;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap_st;
    logic [PW-1:0] snap_rp, snap_tp;
    ticks(3);
    rst_n = 1;
    rx_busy = 1;
    tick();
    // R1 reset state
    chk("R1", "status", int'(status), 8'h15);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "rx_en", int'(rx_en), 0);
    chk("R1", "tx_req", int'(tx_req), 0);
    chk("R1", "pages", int'({rx_page, tx_page}), 0);
    board_ie = 1; tick();
    chk("R10", "irq from por", int'(irq), 1);
    do_cmd(1, 0);
    chk("R5", "por cleared", int'(status[4]), 0);
    chk("R5", "others kept", int'(status[2:0]), 3'b101);
    chk("R10", "irq masked", int'(irq), 0);
    do_mask(3'b001);
    chk("R10", "irq rx_inh", int'(irq), 1);
    board_ie = 0; tick();
    chk("R10", "irq gated", int'(irq), 0);
    board_ie = 1;
    do_cmd(4, 5);
    chk("R3", "armed", int'(rx_en), 1);
    chk("R3", "page", int'(rx_page), 5);
    chk("R10", "irq drop", int'(irq), 0);
    pkt = 1; tick(); pkt = 0;
    chk("R2", "inhibit", int'(status[0]), 1);
    pkt = 1; tick(); pkt = 0;
    chk("R2", "ignored", int'({rx_en, rx_page}), 5);
    pkt = 1; do_cmd(4, 17); pkt = 0;
    chk("R3", "cmd over pkt", int'(rx_en), 1);
    chk("R3", "page 17", int'(rx_page), 17);
    // R11 unknown opcodes
    snap_st = status; snap_rp = rx_page; snap_tp = tx_page;
    do_cmd(0, 31); do_cmd(5, 9); do_cmd(6, 22); do_cmd(7, 3);
    chk("R11", "status", int'(status), int'(snap_st));
    chk("R11", "pages", int'({rx_page, tx_page}), int'({snap_rp, snap_tp}));
    chk("R11", "tx_req", int'(tx_req), 0);
    do_cmd(3, 9);
    chk("R6", "req", int'(tx_req), 1);
    chk("R6", "avail low", int'(status[2]), 0);
    chk("R6", "page", int'(tx_page), 9);
    do_cmd(3, 3);
    chk("R6", "busy ignore", int'(tx_page), 9);
    txd = 1; ack = 1; tick(); txd = 0; ack = 0;
    chk("R7", "ack", int'(status[3:2]), 2'b11);
    chk("R7", "req drop", int'(tx_req), 0);
    do_cmd(3, 12);
    chk("R6", "ack cleared", int'(status[3]), 0);
    txd = 1; ack = 1; bc = 1; tick(); txd = 0; ack = 0; bc = 0;
    chk("R7", "bcast no ack", int'(status[3:2]), 2'b01);
    do_cmd(3, 2);
    txd = 1; ack = 1; do_cmd(2, 0); txd = 0; ack = 0;
    chk("R8", "disabled", int'({status[2], tx_req}), 2'b10);
    chk("R8", "ack untouched", int'(status[3]), 0);
    txd = 1; ack = 1; tick(); txd = 0; ack = 0;
    chk("R7", "stray done", int'(status[3]), 0);
    do_mask(3'b100);
    chk("R10", "irq tx_avail", int'(irq), 1);
    xto = 2'b10; ticks(3);
    chk("R9", "xto", int'(status[7:6]), 2'b10);
    xto = 2'b01; ticks(1);
    chk("R9", "xto lag", int'(status[7:6]), 2'b10);
    ticks(1);
    chk("R9", "xto new", int'(status[7:6]), 2'b01);
    chk("R4", "no recon busy", int'(status[1]), 0);
    rx_busy = 0; do_mask(3'b010);
    ticks(IDLE_CYC + 10);
    chk("R4", "recon set", int'(status[1]), 1);
    chk("R10", "irq recon", int'(irq), 1);
    do_cmd(1, 0);
    chk("R4", "recon clr", int'(status[1]), 0);
    ticks(IDLE_CYC + 10);
    chk("R4", "once per idle", int'(status[1]), 0);
    rx_busy = 1; ticks(6); rx_busy = 0;
    ticks(IDLE_CYC + 10);
    chk("R4", "recon again", int'(status[1]), 1);
    board_ie = 0; tick();
    chk("R10", "irq off", int'(irq), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule